// File: doc/BRIEF.md
# Dual-Lane Dense Matrix Product Engine

This block multiplies two 8×8 matrices of signed 8-bit values that sit in on-chip memories and writes the signed 18-bit product matrix into a third memory. Two multiply-accumulate lanes work side by side. For a given result row, lane 0 builds an even result column and lane 1 the odd column next to it. Both lanes share one A element per cycle and each fetches its own B element. The 512 products therefore take 256 issue cycles.

Operands move through three stages: memory access, multiply-accumulate and write-back. Every operand and result address comes from one issue counter. The result memory has only one write port. When the two lanes finish in the same cycle, the odd-column result is held in a small buffer and written one cycle after the even one. A host pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse, which comes 260 cycles after the start edge.

The controller has four states:
- **ST_IDLE** moves to **ST_RUN** when `start` is seen.
- **ST_RUN** issues one product pair per cycle and moves to **ST_DRAIN** after issue 255.
- **ST_DRAIN** waits three cycles for the pipeline and the buffered write, then moves to **ST_DONE**.
- **ST_DONE** raises `done` for one cycle and returns to **ST_IDLE**.

Top module: `dmm_core`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy`, `done` and `c_we` are all 0. A reset in the middle of a run abandons that run.
- R2: Memory conventions. Element (i,k) of A is at address 8i+k, element (k,j) of B is at address 8k+j, and element (i,j) of C is at address 8i+j. Read data appears one cycle after its address. Lane 0 reads B through port b0 and lane 1 through port b1.
- R3: Every written value equals the sum over k of A(i,k)·B(k,j), taken as signed numbers and kept as an 18-bit two's-complement result.
- R4: Extreme operands give exact results: rows of 127 times columns of 127 give 129032, and rows of 127 times columns of -128 give -130048.
- R5: A run makes exactly 64 writes, one per C address, in ascending address order. The even-column result of each pair is written first and the odd-column result on the next cycle.
- R6: Take S as the rising edge that samples `start`. Write n (n = 0..63) is presented in the cycle after edge S + 8·⌊n/2⌋ + 9 + (n mod 2).
- R7: `done` is high for exactly one cycle, the cycle after edge S+259. A run therefore spans 260 cycles.
- R8: `busy` is high from the cycle after edge S through the `done` cycle, and low after that.
- R9: A `start` that arrives while `busy` is high, including during the `done` cycle, is ignored. It causes no extra writes, no second `done` and no second busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled only when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| a_addr | output | 6 | A memory read address |
| a_rdata | input | 8 | A read data, one cycle after its address |
| b0_addr | output | 6 | B read address for lane 0 (even columns) |
| b0_rdata | input | 8 | B read data for lane 0 |
| b1_addr | output | 6 | B read address for lane 1 (odd columns) |
| b1_rdata | input | 8 | B read data for lane 1 |
| c_we | output | 1 | C memory write enable |
| c_addr | output | 6 | C memory write address |
| c_wdata | output | 18 | C memory write data, signed |

## Verification
All timing is measured from edge S, the clock edge that samples `start`. The bench samples on the falling edge that follows each rising edge. The write of pair p, lane l is due after edge S+8p+9+l. The bench recomputes that cycle for every write it sees and compares it with the cycle counter, alongside the address and the reference value. `done` must appear after edge S+259 and nowhere else within a 300-cycle window, and `busy` is checked at every cycle of that window. Stray `start` pulses are placed mid-run and in the `done` cycle, and the window is watched for any write or busy period they might cause.

// File: rtl/dmm_pkg.sv
package dmm_pkg;

    // Number of parallel multiply-accumulate lanes (power of two, >= 2)
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } dmm_state_e;

endpackage

// File: rtl/dmm_addr_gen.sv
// Issue counter that yields every operand address and dot-product flag.
// The counter is laid out as {row, column group, k}.
module dmm_addr_gen #(
    parameter int N     = 8,
    parameter int LANES = 2,
    localparam int KB   = $clog2(N),
    localparam int LB   = $clog2(LANES),
    localparam int GB   = KB - LB,
    localparam int AW   = 2 * KB,
    localparam int CNTW = 2 * KB + GB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    output logic [AW-1:0]        a_addr,
    output logic [AW-1:0]        b_addr [LANES],
    output logic                 first,
    output logic                 last,
    output logic                 last_issue,
    output logic [AW-LB-1:0]     dest
);

    logic [CNTW-1:0] cnt_q;
    logic [KB-1:0]   kk;
    logic [GB-1:0]   grp;
    logic [KB-1:0]   row;

    assign kk  = cnt_q[KB-1:0];
    assign grp = cnt_q[KB +: GB];
    assign row = cnt_q[KB+GB +: KB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;   // wraps to zero after the final issue
        end
    end

    assign a_addr     = {row, kk};
    assign first      = (kk == '0);
    assign last       = (kk == KB'(N - 1));
    assign last_issue = (cnt_q == '1);
    assign dest       = {row, grp};

    for (genvar l = 0; l < LANES; l++) begin : g_baddr
        assign b_addr[l] = {kk, grp, LB'(l)};
    end

endmodule

// File: rtl/dmm_mac_lane.sv
// One multiply-accumulate lane. The product is sign-extended, and the
// accumulator restarts from zero on the first product of a dot product.
module dmm_mac_lane #(
    parameter int DW = 8,
    parameter int CW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 first,
    input  logic [DW-1:0]        a_op,
    input  logic [DW-1:0]        b_op,
    output logic signed [CW-1:0] sum_next
);

    logic signed [2*DW-1:0] prod;
    logic signed [CW-1:0]   prod_ext;
    logic signed [CW-1:0]   acc_q;

    assign prod     = $signed(a_op) * $signed(b_op);
    assign prod_ext = CW'(prod);           // signed operand, so sign-extended
    assign sum_next = (first ? '0 : acc_q) + prod_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum_next;
        end
    end

    // R3: the accumulator only moves when a product is presented
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));

endmodule

// File: rtl/dmm_wb.sv
// Write-back serialiser: writes lane 0 at once and buffers the other lanes.
module dmm_wb #(
    parameter int CW    = 18,
    parameter int AW    = 6,
    parameter int LANES = 2,
    localparam int LB   = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [AW-LB-1:0]     dest,
    input  logic signed [CW-1:0] sums [LANES],
    output logic                 c_we,
    output logic [AW-1:0]        c_addr,
    output logic [CW-1:0]        c_wdata
);

    logic [CW-1:0]    hold_q [LANES];
    logic [AW-LB-1:0] base_q;
    logic [LB:0]      pend_q;
    logic [LB:0]      idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_we    <= 1'b0;
            c_addr  <= '0;
            c_wdata <= '0;
            base_q  <= '0;
            pend_q  <= '0;
            idx_q   <= '0;
            for (int l = 0; l < LANES; l++) hold_q[l] <= '0;
        end else if (load) begin
            c_we    <= 1'b1;
            c_addr  <= {dest, LB'(0)};
            c_wdata <= sums[0];
            base_q  <= dest;
            pend_q  <= (LB+1)'(LANES - 1);
            idx_q   <= (LB+1)'(1);
            for (int l = 0; l < LANES; l++) hold_q[l] <= sums[l];
        end else if (pend_q != '0) begin
            c_we    <= 1'b1;
            c_addr  <= {base_q, idx_q[LB-1:0]};
            c_wdata <= hold_q[idx_q[LB-1:0]];
            idx_q   <= idx_q + 1'b1;
            pend_q  <= pend_q - 1'b1;
        end else begin
            c_we    <= 1'b0;
        end
    end

    // R6: a new batch never arrives while buffered results are still pending
    p_no_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (pend_q == '0));

    // R5: the lanes of one group land on consecutive addresses in consecutive cycles
    p_pair_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && (c_addr[LB-1:0] != LB'(LANES - 1)))
        |=> (c_we && (c_addr == AW'($past(c_addr) + 1'b1))));

endmodule

// File: rtl/dmm_core.sv
module dmm_core
    import dmm_pkg::*;
#(
    parameter int N   = 8,
    parameter int DW  = 8,
    parameter int CW  = 18,
    localparam int AW = 2 * $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_rdata,
    output logic [AW-1:0] b0_addr,
    input  logic [DW-1:0] b0_rdata,
    output logic [AW-1:0] b1_addr,
    input  logic [DW-1:0] b1_rdata,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic [CW-1:0] c_wdata
);

    localparam int LB        = $clog2(LANES);
    // read latency + accumulate + buffered second write
    localparam int DRAIN_CYC = 3;
    localparam int DCW       = $clog2(DRAIN_CYC + 1);

    dmm_state_e state_q, state_d;
    logic [DCW-1:0] drain_q;
    logic           issue;

    logic [AW-1:0]    g_baddr [LANES];
    logic             g_first, g_last, g_last_issue;
    logic [AW-LB-1:0] g_dest;

    logic             s1_vld, s1_first, s1_last;
    logic [AW-LB-1:0] s1_dest;

    logic [DW-1:0]        b_op [LANES];
    logic signed [CW-1:0] lane_sum [LANES];

    // ---------------- controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            drain_q <= (state_q == ST_DRAIN) ? drain_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                           state_d = ST_RUN;
            ST_RUN:   if (g_last_issue)                    state_d = ST_DRAIN;
            ST_DRAIN: if (drain_q == DCW'(DRAIN_CYC - 1))  state_d = ST_DONE;
            ST_DONE:                                       state_d = ST_IDLE;
            default:                                       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        done  = (state_q == ST_DONE);
        issue = (state_q == ST_RUN);
    end

    // ---------------- stage 1: memory access ----------------
    dmm_addr_gen #(.N(N), .LANES(LANES)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (issue),
        .a_addr     (a_addr),
        .b_addr     (g_baddr),
        .first      (g_first),
        .last       (g_last),
        .last_issue (g_last_issue),
        .dest       (g_dest)
    );

    assign b0_addr = g_baddr[0];
    assign b1_addr = g_baddr[1];
    assign b_op[0] = b0_rdata;
    assign b_op[1] = b1_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_dest  <= '0;
        end else begin
            s1_vld   <= issue;
            s1_first <= g_first;
            s1_last  <= g_last;
            s1_dest  <= g_dest;
        end
    end

    // ---------------- stage 2: multiply-accumulate ----------------
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dmm_mac_lane #(.DW(DW), .CW(CW)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (s1_vld),
            .first    (s1_first),
            .a_op     (a_rdata),
            .b_op     (b_op[l]),
            .sum_next (lane_sum[l])
        );
    end

    // ---------------- stage 3: write-back ----------------
    dmm_wb #(.CW(CW), .AW(AW), .LANES(LANES)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (s1_vld && s1_last),
        .dest    (s1_dest),
        .sums    (lane_sum),
        .c_we    (c_we),
        .c_addr  (c_addr),
        .c_wdata (c_wdata)
    );

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an idle block never writes
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !c_we);

    // R9: a start while running does not restart or end the run
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: tb/dmm_core_tb_top.sv
module dmm_core_tb_top;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int CW = 18;
    localparam int AW = 6;
    localparam int NV = 6;

    // Columns: mode, seed, check C(0,0)?, expected C(0,0), stray starts?
    localparam int VEC [NV][5] = '{
        '{0, 1, 0, 0,       0},
        '{0, 7, 0, 0,       1},
        '{1, 3, 0, 0,       0},
        '{2, 0, 1, 129032,  0},
        '{3, 0, 1, -130048, 1},
        '{4, 5, 0, 0,       0}
    };

    logic          clk = 1'b0;
    logic          rst_n, start;
    logic          busy, done;
    logic [AW-1:0] a_addr, b0_addr, b1_addr, c_addr;
    logic [DW-1:0] a_rdata, b0_rdata, b1_rdata;
    logic          c_we;
    logic [CW-1:0] c_wdata;

    logic [DW-1:0] amem [N*N];
    logic [DW-1:0] bmem [N*N];
    int            expc [N*N];
    int            gotc [N*N];

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // synchronous-read memory models, one cycle of latency
    always @(posedge clk) begin
        a_rdata  <= amem[a_addr];
        b0_rdata <= bmem[b0_addr];
        b1_rdata <= bmem[b1_addr];
    end

    dmm_core #(.N(N), .DW(DW), .CW(CW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .a_addr   (a_addr),
        .a_rdata  (a_rdata),
        .b0_addr  (b0_addr),
        .b0_rdata (b0_rdata),
        .b1_addr  (b1_addr),
        .b1_rdata (b1_rdata),
        .c_we     (c_we),
        .c_addr   (c_addr),
        .c_wdata  (c_wdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gen(int mode, int seed, int idx, int isb);
        int h;
        h = idx * 73 + seed * 151 + isb * 29 + 7;
        h = (h * h + seed * 13) % 251 - 125;
        case (mode)
            1:       return isb ? h : ((idx / 8 == idx % 8) ? 1 : 0);
            2:       return 127;
            3:       return isb ? -128 : 127;
            4:       return isb ? h : ((idx % 2) ? -100 : 90);
            default: return h;
        endcase
    endfunction

    task automatic load_mats(int mode, int seed);
        for (int i = 0; i < N * N; i++) begin
            amem[i] = DW'(gen(mode, seed, i, 0));
            bmem[i] = DW'(gen(mode, seed, i, 1));
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int s;
                logic [CW-1:0] t;
                s = 0;
                for (int k = 0; k < N; k++)
                    s += int'($signed(amem[i*N+k])) * int'($signed(bmem[k*N+j]));
                t = CW'(s);
                expc[i*N+j] = int'($signed(t));
            end
        end
    endtask

    // Runs one product; all timing is relative to S, the edge sampling start.
    task automatic run_one(int mode, int seed, int chk00, int e00, int stray);
        int nw, bad_addr, bad_data, bad_time, bad_busy, n_done, done_rel;
        nw = 0; bad_addr = 0; bad_data = 0; bad_time = 0; bad_busy = 0;
        n_done = 0; done_rel = -1;
        load_mats(mode, seed);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;            // now just past edge S
        for (int rel = 0; rel <= 300; rel++) begin
            if (rel > 0) @(negedge clk);
            start = 1'b0;
            if (stray != 0 && rel == 100) start = 1'b1;   // R9 mid-run
            if (c_we) begin
                if (nw < N * N) begin
                    if (int'(c_addr) != nw) bad_addr++;
                    if (rel != 8 * (nw / 2) + 9 + (nw % 2)) bad_time++;
                end
                if (int'($signed(c_wdata)) != expc[c_addr]) bad_data++;
                gotc[c_addr] = int'($signed(c_wdata));
                nw++;
            end
            if (busy != (rel <= 259)) bad_busy++;
            if (done) begin
                n_done++;
                if (done_rel < 0) done_rel = rel;
                if (stray != 0) start = 1'b1;             // R9 during done
            end
        end
        start = 1'b0;
        check(nw == N * N, "R5", "write count", nw, N * N);
        check(bad_addr == 0, "R5", "writes out of address order", bad_addr, 0);
        check(bad_data == 0, "R3", "mismatching results", bad_data, 0);  // R2 R3
        check(bad_time == 0, "R6", "writes in wrong cycle", bad_time, 0);
        check(done_rel == 259, "R7", "done cycle after S", done_rel, 259);
        check(n_done == 1, "R7", "done pulse count", n_done, 1);
        check(bad_busy == 0, "R8", "cycles with wrong busy", bad_busy, 0);
        if (stray != 0) begin
            check(nw == N * N && n_done == 1 && !busy, "R9",
                  "stray start caused extra activity", nw, N * N);
        end
        if (chk00 != 0) check(gotc[0] == e00, "R4", "extreme C(0,0)", gotc[0], e00);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        for (int i = 0; i < N * N; i++) begin
            amem[i] = '0; bmem[i] = '0; gotc[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !c_we, "R1", "outputs under reset",
              {busy, done, c_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !c_we, "R1", "outputs after reset release",
              {busy, done, c_we}, 0);

        // R1: reset in the middle of a run abandons it
        load_mats(0, 2);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !c_we, "R1", "outputs after mid-run reset",
              {busy, done, c_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_one(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            repeat (3) @(negedge clk);
        end

        // R9: after an ignored start the block stays quiet
        begin
            int extra;
            extra = 0;
            for (int t = 0; t < 300; t++) begin
                @(negedge clk);
                if (c_we || busy || done) extra++;
            end
            check(extra == 0, "R9", "activity after ignored start", extra, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule